// File: doc/BRIEF.md
# PLL Operating Mode Strap Latch with Software Override

This block decides the operating mode of a clock buffer's PLL. A board strap, already resolved into a two-bit code by an external three-level comparator, selects low-bandwidth filtering, bypass, or high-bandwidth filtering. The block captures the strap once, on the first clock edge after cold reset is released. It then holds that mode and drives two PLL control lines: bypass select and bandwidth select.

One configuration byte is visible on a plain register port. The top two bits of this byte always report the mode captured from the strap. A low field of the byte can hold a programmed mode. That field can be written only after software sets an enable bit. The programmed mode does not reach the PLL when it is written. It is applied at the next warm reset.

The register port is a control interface. It has a single-cycle write strobe and combinational read data. It has no valid/ready handshake and never applies back-pressure, because every write completes in the cycle it is presented.

Top module: `pll_mode_strap`

## Requirements
- R1: The strap code is decoded as follows: 00 (low level) selects low bandwidth, 01 (middle level) selects bypass, 10 (high level) selects high bandwidth, and 11 is treated as the middle level (bypass).
- R2: Read bits [7:6] report the strap-captured mode as 00 = low bandwidth, 01 = bypass, 11 = high bandwidth. They do so at all times, including while a different override mode is active.
- R3: The strap is sampled only on the first clock edge after cold reset is released. Later changes to the strap, and warm resets, do not change the captured mode.
- R4: Bit 3 (override enable) is writable on every write. Bits [2:1] (override mode) take the written value only when the stored bit 3 is already 1 before that write; otherwise the write leaves them unchanged.
- R5: Writing the override field or the enable bit does not change the PLL control outputs until a warm reset occurs.
- R6: At a warm reset, the active mode becomes the override field if bit 3 is 1. The field uses the same encoding as R2, with code 10 meaning low bandwidth. If bit 3 is 0, the active mode becomes the strap-captured mode.
- R7: `pll_bypass_sel` is 1 only in bypass mode. `pll_high_bw_sel` is 1 only in high-bandwidth mode. Both are 0 in low-bandwidth mode.
- R8: Cold reset clears the whole configuration byte to 0x00 and drives low-bandwidth mode (both outputs 0). A warm reset keeps every register bit and the captured mode.
- R9: Read bits 5, 4 and 0 always read 0. Writes to them have no effect.
- R10: After the override enable is cleared, the next warm reset restores the strap-captured mode to the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| cold_rst_n | input | 1 | Asynchronous active-low cold reset |
| warm_rst | input | 1 | Synchronous active-high warm reset pulse |
| strap_code | input | 2 | Pre-digitized three-level strap code |
| cfg_wr_en | input | 1 | Write strobe for the configuration byte |
| cfg_wr_data | input | 8 | Write data |
| cfg_rd_data | output | 8 | Configuration byte read data |
| pll_bypass_sel | output | 1 | 1 = route the input clock past the PLL |
| pll_high_bw_sel | output | 1 | 1 = PLL high-bandwidth filtering |

## Verification
On every cycle, the assertions check the following:
- The captured mode never moves once taken.
- The override field stays frozen across writes made while the enable bit is clear.
- The active mode changes only on a warm reset.
- The two PLL controls are never both high.
- The readback code never shows the unused value 10.

Only the bench scenarios can show the following:
- The mapping from each strap level to a mode.
- The delay of an override until a warm reset.
- The code-10 fallback to low bandwidth.
- The return to the strapped mode once the enable is cleared.
- The exact values cleared by a cold reset.

// File: rtl/pll_mode_strap_pkg.sv
package pll_mode_strap_pkg;
  localparam int CFG_W = 8;
  localparam int RB_HI = 7;
  localparam int RB_LO = 6;
  localparam int OVR_EN_BIT = 3;
  localparam int OVR_HI = 2;
  localparam int OVR_LO = 1;
  localparam int CODE_W = RB_HI - RB_LO + 1;

  typedef enum logic [CODE_W-1:0] {
    MODE_LOW  = 2'b00,
    MODE_BYP  = 2'b01,
    MODE_HIGH = 2'b11
  } pll_mode_e;

  // Register field code to mode; the unused code 10 falls back to low bandwidth.
  function automatic pll_mode_e field_to_mode(input logic [CODE_W-1:0] c);
    case (c)
      2'b01:   return MODE_BYP;
      2'b11:   return MODE_HIGH;
      default: return MODE_LOW;
    endcase
  endfunction
endpackage

// File: rtl/pll_strap_decode.sv
module pll_strap_decode
  import pll_mode_strap_pkg::*;
(
  input  logic [1:0] strap_code,
  output pll_mode_e  strap_mode
);
  always_comb begin
    case (strap_code)
      2'b00:   strap_mode = MODE_LOW;
      2'b10:   strap_mode = MODE_HIGH;
      default: strap_mode = MODE_BYP;  // middle level and the unused code
    endcase
  end
endmodule

// File: rtl/pll_strap_latch.sv
module pll_strap_latch
  import pll_mode_strap_pkg::*;
(
  input  logic      clk,
  input  logic      cold_rst_n,
  input  pll_mode_e strap_mode,
  output logic      take,
  output logic      taken,
  output pll_mode_e latched_mode
);
  assign take = ~taken;

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      taken        <= 1'b0;
      latched_mode <= MODE_LOW;
    end else if (take) begin
      taken        <= 1'b1;
      latched_mode <= strap_mode;
    end
  end

  // R3: once captured, the strap mode never changes until cold reset
  p_strap_held_r3: assert property (@(posedge clk) disable iff (!cold_rst_n)
    taken |=> $stable(latched_mode));

  // R2: readback code never takes the unused value 10
  p_rb_code_legal_r2: assert property (@(posedge clk) disable iff (!cold_rst_n)
    latched_mode != 2'b10);
endmodule

// File: rtl/pll_cfg_reg.sv
module pll_cfg_reg
  import pll_mode_strap_pkg::*;
(
  input  logic             clk,
  input  logic             cold_rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  pll_mode_e        latched_mode,
  output logic             ovr_en,
  output logic [CODE_W-1:0] ovr_code,
  output logic [CFG_W-1:0] rd_data
);
  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      ovr_en   <= 1'b0;
      ovr_code <= '0;
    end else if (wr_en) begin
      ovr_en <= wr_data[OVR_EN_BIT];
      if (ovr_en) ovr_code <= wr_data[OVR_HI:OVR_LO];
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[RB_HI:RB_LO]   = latched_mode;
    rd_data[OVR_EN_BIT]    = ovr_en;
    rd_data[OVR_HI:OVR_LO] = ovr_code;
  end

  // R4: a write while the enable is clear leaves the override field alone
  p_ovr_locked_r4: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (wr_en && !ovr_en) |=> $stable(ovr_code));

  // R4: without a write nothing in the byte moves
  p_cfg_quiet_r4: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !wr_en |=> ($stable(ovr_code) && $stable(ovr_en)));
endmodule

// File: rtl/pll_mode_apply.sv
module pll_mode_apply
  import pll_mode_strap_pkg::*;
(
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              take,
  input  pll_mode_e         strap_mode,
  input  logic              warm_rst,
  input  logic              ovr_en,
  input  logic [CODE_W-1:0] ovr_code,
  input  pll_mode_e         latched_mode,
  output pll_mode_e         active_mode
);
  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n)   active_mode <= MODE_LOW;
    else if (take)     active_mode <= strap_mode;
    else if (warm_rst) active_mode <= ovr_en ? field_to_mode(ovr_code) : latched_mode;
  end

  // R5: outside the capture edge and warm reset, the applied mode holds
  p_mode_hold_r5: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (!take && !warm_rst) |=> $stable(active_mode));

  // R6: a warm reset with override disabled lands on the captured mode
  p_warm_strap_r6: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (!take && warm_rst && !ovr_en) |=> (active_mode == $past(latched_mode)));
endmodule

// File: rtl/pll_mode_strap.sv
module pll_mode_strap
  import pll_mode_strap_pkg::*;
(
  input  logic             clk,
  input  logic             cold_rst_n,
  input  logic             warm_rst,
  input  logic [1:0]       strap_code,
  input  logic             cfg_wr_en,
  input  logic [CFG_W-1:0] cfg_wr_data,
  output logic [CFG_W-1:0] cfg_rd_data,
  output logic             pll_bypass_sel,
  output logic             pll_high_bw_sel
);
  pll_mode_e         strap_mode, latched_mode, active_mode;
  logic              take, taken, ovr_en;
  logic [CODE_W-1:0] ovr_code;

  pll_strap_decode u_dec (.strap_code(strap_code), .strap_mode(strap_mode));

  pll_strap_latch u_latch (
    .clk(clk), .cold_rst_n(cold_rst_n), .strap_mode(strap_mode),
    .take(take), .taken(taken), .latched_mode(latched_mode));

  pll_cfg_reg u_cfg (
    .clk(clk), .cold_rst_n(cold_rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .latched_mode(latched_mode), .ovr_en(ovr_en), .ovr_code(ovr_code),
    .rd_data(cfg_rd_data));

  pll_mode_apply u_apply (
    .clk(clk), .cold_rst_n(cold_rst_n), .take(take), .strap_mode(strap_mode),
    .warm_rst(warm_rst), .ovr_en(ovr_en), .ovr_code(ovr_code),
    .latched_mode(latched_mode), .active_mode(active_mode));

  assign pll_bypass_sel  = (active_mode == MODE_BYP);
  assign pll_high_bw_sel = (active_mode == MODE_HIGH);

  // R7: bypass and high bandwidth are never requested together
  p_ctl_exclusive_r7: assert property (@(posedge clk) disable iff (!cold_rst_n)
    $onehot0({pll_bypass_sel, pll_high_bw_sel}));

  // R9: unused byte bits read zero
  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (cfg_rd_data[5:4] == 2'b00) && !cfg_rd_data[0]);

  // R3: the capture happens exactly once after cold reset
  p_taken_once_r3: assert property (@(posedge clk) disable iff (!cold_rst_n)
    taken |=> taken);
endmodule

// File: tb/pll_mode_strap_test.sv
module pll_mode_strap_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       cold_rst_n = 1'b0;
  logic       warm_rst = 1'b0;
  logic [1:0] strap_code = 2'b00;
  logic       cfg_wr_en = 1'b0;
  logic [7:0] cfg_wr_data = 8'h00;
  logic [7:0] cfg_rd_data;
  logic       pll_bypass_sel, pll_high_bw_sel;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_mode_strap uut (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst(warm_rst), .strap_code(strap_code),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
    .pll_bypass_sel(pll_bypass_sel), .pll_high_bw_sel(pll_high_bw_sel));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // outputs packed as {bypass, high_bw}
  function automatic logic [7:0] outs();
    return {6'b0, pll_bypass_sel, pll_high_bw_sel};
  endfunction

  function automatic logic [7:0] mode_outs(input logic [1:0] m);
    return {6'b0, m == 2'b01, m == 2'b11};
  endfunction

  function automatic logic [7:0] byte_of(input logic [1:0] rb, input logic en, input logic [1:0] ov);
    return {rb, 2'b00, en, ov, 1'b0};
  endfunction

  task automatic cold(input logic [1:0] code);
    @(negedge clk);
    cold_rst_n = 1'b0;
    strap_code = code;
    repeat (2) @(negedge clk);
    chk("R8 cold byte", cfg_rd_data, 8'h00);
    chk("R8 cold outs", outs(), 8'h00);
    cold_rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    cfg_wr_en = 1'b1;
    cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic warm();
    warm_rst = 1'b1;
    @(negedge clk);
    warm_rst = 1'b0;
  endtask

  task automatic t_decode(input logic [1:0] code, input logic [1:0] mode);
    cold(code);
    chk("R1/R2 readback", cfg_rd_data, byte_of(mode, 1'b0, 2'b00));
    chk("R1/R7 outputs", outs(), mode_outs(mode));
  endtask

  task automatic t_no_resample();
    cold(2'b10);
    strap_code = 2'b00;
    repeat (3) @(negedge clk);
    chk("R3 strap change", cfg_rd_data, byte_of(2'b11, 1'b0, 2'b00));
    warm();
    chk("R3 warm no resample", cfg_rd_data, byte_of(2'b11, 1'b0, 2'b00));
    chk("R3 outs after warm", outs(), mode_outs(2'b11));
  endtask

  task automatic t_override();
    cold(2'b00);
    wr(8'h06);
    chk("R4 locked field", cfg_rd_data, byte_of(2'b00, 1'b0, 2'b00));
    wr(8'h08);
    wr(8'h0E);
    chk("R4 field written", cfg_rd_data, byte_of(2'b00, 1'b1, 2'b11));
    repeat (2) @(negedge clk);
    chk("R5 no effect yet", outs(), mode_outs(2'b00));
    warm();
    chk("R6 override applied", outs(), mode_outs(2'b11));
    chk("R2 readback keeps strap", cfg_rd_data, byte_of(2'b00, 1'b1, 2'b11));
    chk("R8 warm keeps byte", cfg_rd_data, byte_of(2'b00, 1'b1, 2'b11));
    wr(8'hFB);
    chk("R9 unused bits zero", cfg_rd_data, byte_of(2'b00, 1'b1, 2'b01));
    chk("R5 write after warm", outs(), mode_outs(2'b11));
    wr(8'h0C);
    warm();
    chk("R6 code 10 is low", outs(), mode_outs(2'b00));
  endtask

  task automatic t_restore();
    cold(2'b10);
    wr(8'h08);
    wr(8'h0A);
    warm();
    chk("R6 bypass override", outs(), mode_outs(2'b01));
    wr(8'h00);
    chk("R4 enable cleared", cfg_rd_data, byte_of(2'b11, 1'b0, 2'b00));
    chk("R5 still bypass", outs(), mode_outs(2'b01));
    warm();
    chk("R10 strap restored", outs(), mode_outs(2'b11));
    wr(8'h08);
    wr(8'h0A);
    cold(2'b01);
    chk("R8 cold clears override", cfg_rd_data, byte_of(2'b01, 1'b0, 2'b00));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset byte", cfg_rd_data, 8'h00);
    chk("R8 reset outs", outs(), 8'h00);
    t_decode(2'b00, 2'b00);
    t_decode(2'b01, 2'b01);
    t_decode(2'b10, 2'b11);
    t_decode(2'b11, 2'b01);
    t_no_resample();
    t_override();
    t_restore();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule